// File: doc/BRIEF.md
# Edge/Level Interrupt Request Latch

This block turns eight synchronised interrupt input lines into an eight-bit pending-request register. Each line has its own trigger-mode bit. In level mode the request bit simply follows the line. In edge mode the request bit is set by a low-to-high transition, which the block finds by comparing the line with a shadow copy of its previous level. Once set, an edge request stays pending until it is acknowledged or the controller is reinitialised. Some lines can be hard-wired to edge mode: a parameterised writable-bit mask is ANDed into every write of the trigger-mode register.

A mask register does not stop a request from being latched. It only changes what the block reports. The `active` output leaves masked requests out, and each rising transition produces a one-cycle event with a two-bit status code that says whether the request was newly latched, was already pending, or sits on a masked line. An acknowledge strobe with a line index clears that line's request if the line is in edge mode. A reinitialise strobe zeroes the level shadow and drops every edge-mode request while keeping level-mode requests. Priority resolution, acknowledge sequencing and the programming bus belong to the surrounding controller.

Top module: `irq_req_latch`

## Requirements
- R1: A line whose trigger-mode bit is 1 (level mode) has its request bit equal to the line value sampled at the previous clock edge: a high input sets it and a low input clears it, whether or not an acknowledge arrives.
- R2: A line whose trigger-mode bit is 0 (edge mode) sets its request bit only at a clock edge where the input is high and the stored previous level is low. A low input or a held-high input leaves the request bit unchanged.
- R3: A trigger-mode write stores the write data ANDed with the parameter `WRITABLE` (default 8'hF8; 8'hDE suits a secondary controller). Bits cleared in `WRITABLE` always read 0, so those lines are always in edge mode.
- R4: Every rising transition on a line pulses `evt_o[i]` for one cycle, registered at the same edge that updates the request. `status_o[2i+1:2i]` then reads 2'b01 when the request was newly latched and 2'b00 when it was already pending.
- R5: On a rising transition of a line whose mask bit is 1, the status code is 2'b11. The request bit is still latched, but `active_o` for that line stays 0.
- R6: An acknowledge (`ack_valid` with index `ack_idx`) clears the request bit of that line at the next edge if the line is in edge mode. A level-mode request is not affected. A rising transition in the same cycle wins over the acknowledge.
- R7: A `reinit` pulse zeroes the previous-level shadow, clears the request bits of edge-mode lines, keeps the request bits of level-mode lines, and produces no event. An edge-mode line still held high therefore latches again, with code 2'b01, at the next edge without `reinit`.
- R8: While `rst_n` is low at a clock edge, the request, trigger-mode, mask and shadow registers and the event outputs all clear to 0.
- R9: A mask write stores the data unchanged in `mask_o`. `active_o` equals `req_o` with the masked bits removed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| line_i | input | 8 | Interrupt input levels, already synchronised to clk |
| mode_we_i | input | 1 | Trigger-mode register write strobe |
| mode_wd_i | input | 8 | Trigger-mode write data, 1 = level mode |
| mask_we_i | input | 1 | Mask register write strobe |
| mask_wd_i | input | 8 | Mask write data, 1 = masked |
| ack_valid_i | input | 1 | Acknowledge strobe |
| ack_idx_i | input | 3 | Line index being acknowledged |
| reinit_i | input | 1 | Controller reinitialise pulse |
| req_o | output | 8 | Pending-request register |
| mode_o | output | 8 | Trigger-mode register |
| mask_o | output | 8 | Mask register |
| active_o | output | 8 | Pending requests that are not masked |
| evt_o | output | 8 | One-cycle pulse per line on a rising transition |
| status_o | output | 16 | Two-bit status code per line, valid while evt_o is high |

## Verification
The hardest situation to reach from the ports is the re-latch after reinitialisation. It needs an edge-mode line whose request is already pending and whose input stays high, next to a level-mode line that is also high. The bench builds that state first, pulses `reinit` for a single cycle, and then checks two edges in turn. At the first edge the edge-mode request must be gone and the level-mode request kept. At the second edge the edge-mode line must latch again as a new request, because the shadow was zeroed. The "already pending" status code is also indirect to reach: the bench has to drop a latched edge line low and raise it again without an acknowledge in between.

// File: rtl/irql_pkg.sv
// Package: shared types for the interrupt request latch.
// Assumes nothing beyond IEEE 1800-2017 semantics.
package irql_pkg;

    // Per-line report code, valid while the line's event pulse is high
    typedef enum logic [1:0] {
        ST_ALREADY = 2'b00,
        ST_NEW     = 2'b01,
        ST_MASKED  = 2'b11
    } irql_status_e;

endpackage

// File: rtl/irql_cfg.sv
// Module: irql_cfg
// Holds the trigger-mode and mask registers. Every trigger-mode write is
// ANDed with WRITABLE, so lines whose bit is 0 there stay in edge mode.
// Assumes: write strobes last one cycle each; synchronous active-low reset.
module irql_cfg #(
    parameter int          N        = 8,
    parameter logic [N-1:0] WRITABLE = 8'hF8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         mode_we,
    input  logic [N-1:0] mode_wd,
    input  logic         mask_we,
    input  logic [N-1:0] mask_wd,
    output logic [N-1:0] mode_q,
    output logic [N-1:0] mask_q
);

    // Trigger-mode register with the fixed non-writable bits forced to 0
    always_ff @(posedge clk) begin
        if (!rst_n)       mode_q <= '0;
        else if (mode_we) mode_q <= mode_wd & WRITABLE;
    end

    // Mask register, stored without change
    always_ff @(posedge clk) begin
        if (!rst_n)       mask_q <= '0;
        else if (mask_we) mask_q <= mask_wd;
    end

    // R3
    fixed_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q & ~WRITABLE) == '0);

    // R9
    mask_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mask_we |=> mask_q == $past(mask_wd));

endmodule

// File: rtl/irql_ack_dec.sv
// Module: irql_ack_dec
// Turns an acknowledge strobe and a line index into a one-hot hit vector.
// Assumes: ack_idx is below N whenever ack_valid is high.
module irql_ack_dec #(
    parameter int N    = 8,
    localparam int IDXW = $clog2(N)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ack_valid,
    input  logic [IDXW-1:0] ack_idx,
    output logic [N-1:0]    ack_hit
);

    // One-hot decode of the acknowledged line
    always_comb begin
        ack_hit = '0;
        for (int i = 0; i < N; i++) begin
            if (ack_valid && (ack_idx == IDXW'(i))) ack_hit[i] = 1'b1;
        end
    end

    // R6
    ack_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ack_hit));

endmodule

// File: rtl/irql_line.sv
// Module: irql_line
// One request line: holds the previous-level shadow, the request bit and
// the event/status report for a rising transition.
// Assumes: lvl_in is synchronous to clk; ack_hit and reinit are one-cycle strobes.
module irql_line
    import irql_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       lvl_in,
    input  logic       level_mode,
    input  logic       masked,
    input  logic       ack_hit,
    input  logic       reinit,
    output logic       req_o,
    output logic       evt_o,
    output logic [1:0] code_o
);

    logic         prev_q;
    logic         req_q;
    logic         evt_q;
    irql_status_e code_q;
    logic         rise;
    logic         req_kept;
    logic         req_next;
    irql_status_e next_code;

    // Transition detection and the next request value
    always_comb begin
        rise      = lvl_in & ~prev_q;
        req_kept  = req_q & ~(ack_hit & ~level_mode);
        req_next  = level_mode ? lvl_in : (req_kept | rise);
        next_code = masked ? ST_MASKED : (req_kept ? ST_ALREADY : ST_NEW);
    end

    // Shadow, request and report registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
            req_q  <= 1'b0;
            evt_q  <= 1'b0;
            code_q <= ST_ALREADY;
        end else if (reinit) begin
            prev_q <= 1'b0;
            if (!level_mode) req_q <= 1'b0;
            evt_q  <= 1'b0;
        end else begin
            prev_q <= lvl_in;
            req_q  <= req_next;
            evt_q  <= rise;
            if (rise) code_q <= next_code;
        end
    end

    assign req_o  = req_q;
    assign evt_o  = evt_q;
    assign code_o = code_q;

    // R1
    level_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (level_mode && !reinit) |=> req_q == $past(lvl_in));

    // R2
    edge_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!level_mode && !reinit && !ack_hit && !rise) |=> $stable(req_q));

    // R2
    edge_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!level_mode && !reinit && rise) |=> req_q);

    // R5
    masked_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!reinit && rise && masked) |=> (evt_q && code_q == ST_MASKED));

    // R6
    ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_hit && !level_mode && !reinit && !rise) |=> !req_q);

    // R7
    reinit_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reinit && !level_mode) |=> (!req_q && !evt_q && !prev_q));

endmodule

// File: rtl/irq_req_latch.sv
// Module: irq_req_latch
// Top of the edge/level interrupt request latch: configuration registers,
// acknowledge decoder and one line cell per input.
// Assumes: line_i is already synchronised; synchronous active-low reset.
module irq_req_latch #(
    parameter int          N        = 8,
    parameter logic [N-1:0] WRITABLE = 8'hF8,
    localparam int         IDXW     = $clog2(N)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N-1:0]    line_i,
    input  logic            mode_we_i,
    input  logic [N-1:0]    mode_wd_i,
    input  logic            mask_we_i,
    input  logic [N-1:0]    mask_wd_i,
    input  logic            ack_valid_i,
    input  logic [IDXW-1:0] ack_idx_i,
    input  logic            reinit_i,
    output logic [N-1:0]    req_o,
    output logic [N-1:0]    mode_o,
    output logic [N-1:0]    mask_o,
    output logic [N-1:0]    active_o,
    output logic [N-1:0]    evt_o,
    output logic [2*N-1:0]  status_o
);

    logic [N-1:0] ack_hit;

    irql_cfg #(.N(N), .WRITABLE(WRITABLE)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode_we (mode_we_i),
        .mode_wd (mode_wd_i),
        .mask_we (mask_we_i),
        .mask_wd (mask_wd_i),
        .mode_q  (mode_o),
        .mask_q  (mask_o)
    );

    irql_ack_dec #(.N(N)) u_ack (
        .clk       (clk),
        .rst_n     (rst_n),
        .ack_valid (ack_valid_i),
        .ack_idx   (ack_idx_i),
        .ack_hit   (ack_hit)
    );

    for (genvar g = 0; g < N; g++) begin : g_line
        irql_line u_line (
            .clk        (clk),
            .rst_n      (rst_n),
            .lvl_in     (line_i[g]),
            .level_mode (mode_o[g]),
            .masked     (mask_o[g]),
            .ack_hit    (ack_hit[g]),
            .reinit     (reinit_i),
            .req_o      (req_o[g]),
            .evt_o      (evt_o[g]),
            .code_o     (status_o[2*g +: 2])
        );
    end

    // Reported requests leave out masked lines
    always_comb active_o = req_o & ~mask_o;

    // R8
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (req_o == '0 && mode_o == '0 && mask_o == '0 && evt_o == '0));

endmodule

// File: tb/sim_irq_req_latch.sv
// Bench: directed scenarios for irq_req_latch, one task each.
module sim_irq_req_latch;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  line_i = '0;
    logic        mode_we_i = 1'b0;
    logic [7:0]  mode_wd_i = '0;
    logic        mask_we_i = 1'b0;
    logic [7:0]  mask_wd_i = '0;
    logic        ack_valid_i = 1'b0;
    logic [2:0]  ack_idx_i = '0;
    logic        reinit_i = 1'b0;
    logic [7:0]  req_o, mode_o, mask_o, active_o, evt_o;
    logic [15:0] status_o;

    int checks = 0;
    int errors = 0;

    irq_req_latch u0 (.*);

    always #10 clk = ~clk;

    // One clock edge, then settle at the falling edge
    task automatic step();
        @(posedge clk);
        @(negedge clk);
        mode_we_i   = 1'b0;
        mask_we_i   = 1'b0;
        ack_valid_i = 1'b0;
        reinit_i    = 1'b0;
    endtask

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n  = 1'b0;
        line_i = '0;
        step();
        rst_n = 1'b1;
    endtask

    task automatic t_reset();
        do_reset();
        chk("R8", "req", req_o, 0);
        chk("R8", "mode", mode_o, 0);
        chk("R8", "mask", mask_o, 0);
        chk("R8", "evt", evt_o, 0);
    endtask

    task automatic t_mode_write();
        do_reset();
        mode_we_i = 1'b1; mode_wd_i = 8'hFF; step();
        chk("R3", "mode FF", mode_o, 8'hF8);
        mode_we_i = 1'b1; mode_wd_i = 8'h07; step();
        chk("R3", "mode 07", mode_o, 8'h00);
        line_i[1] = 1'b1; step();
        line_i[1] = 1'b0; step();
        chk("R3", "forced edge line1 keeps req", req_o[1], 1);
    endtask

    task automatic t_edge();
        do_reset();
        line_i[3] = 1'b1; step();
        chk("R2", "edge latch", req_o[3], 1);
        chk("R4", "evt new", evt_o[3], 1);
        chk("R4", "code new", status_o[7:6], 2'b01);
        step();
        chk("R2", "held high no evt", evt_o[3], 0);
        line_i[3] = 1'b0; step();
        chk("R2", "low keeps req", req_o[3], 1);
        line_i[3] = 1'b1; step();
        chk("R4", "evt again", evt_o[3], 1);
        chk("R4", "code already", status_o[7:6], 2'b00);
    endtask

    task automatic t_ack();
        do_reset();
        line_i[3] = 1'b1; step();
        ack_valid_i = 1'b1; ack_idx_i = 3'd3; step();
        chk("R6", "edge ack clears", req_o[3], 0);
        step();
        chk("R2", "held high no relatch", req_o[3], 0);
        mode_we_i = 1'b1; mode_wd_i = 8'h10; step();
        line_i[4] = 1'b1; step();
        chk("R1", "level set", req_o[4], 1);
        ack_valid_i = 1'b1; ack_idx_i = 3'd4; step();
        chk("R6", "level ack keeps", req_o[4], 1);
        line_i[4] = 1'b0; step();
        chk("R1", "level clear", req_o[4], 0);
    endtask

    task automatic t_mask();
        do_reset();
        mask_we_i = 1'b1; mask_wd_i = 8'h20; step();
        chk("R9", "mask readback", mask_o, 8'h20);
        line_i[5] = 1'b1; step();
        chk("R5", "masked evt", evt_o[5], 1);
        chk("R5", "masked code", status_o[11:10], 2'b11);
        chk("R5", "masked req latched", req_o[5], 1);
        chk("R5", "masked not active", active_o[5], 0);
        mask_we_i = 1'b1; mask_wd_i = 8'h00; step();
        chk("R9", "unmasked active", active_o, 8'h20);
    endtask

    task automatic t_reinit();
        do_reset();
        mode_we_i = 1'b1; mode_wd_i = 8'h80; step();
        line_i[7] = 1'b1; line_i[6] = 1'b1; step();
        chk("R7", "setup both pending", req_o[7:6], 2'b11);
        reinit_i = 1'b1; step();
        chk("R7", "edge dropped", req_o[6], 0);
        chk("R7", "level kept", req_o[7], 1);
        chk("R7", "no evt on reinit", evt_o[6], 0);
        step();
        chk("R7", "relatch", req_o[6], 1);
        chk("R7", "relatch evt", evt_o[6], 1);
        chk("R7", "relatch code", status_o[13:12], 2'b01);
    endtask

    // Watchdog: a hung run counts as one failed check
    initial begin
        repeat (5000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_mode_write();
        t_edge();
        t_ack();
        t_mask();
        t_reinit();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule